// File: doc/BRIEF.md
# Logic Analyzer Host Command Decoder

This block sits behind a serial receiver and turns the byte stream sent by a logic analyzer host into configuration registers and control pulses. Each accepted byte is either an opcode or an argument byte. An opcode with bit 7 clear is a short command and acts at once: 0x00 requests a reset and 0x01 arms the capture. An opcode with bit 7 set opens a long command. The four bytes that follow it form a 32-bit argument, sent least-significant byte first. That word is written to one of six registers only once the fourth argument byte has arrived.

A host brings the decoder back into step by sending five zero bytes in a row. Whatever the byte alignment, some of those zeros finish any partial long command as argument data, and the remaining zeros are taken as reset opcodes. A byte is accepted on a rising clock edge when its valid flag is high. All outputs are registered, so each result appears in the cycle after the byte that causes it. The registers keep their values across a reset command; that command only produces a pulse.

Top module: `la_cmd_decoder`

## Requirements
- R1: After the reset input (rstN low) is released, all six registers read 0 and regWe, resetPulse and armPulse are all 0.
- R2: A byte 0x00 accepted as an opcode makes resetPulse high for the one cycle after it is accepted.
- R3: A byte 0x01 accepted as an opcode makes armPulse high for the one cycle after it is accepted. resetPulse and armPulse are never high together.
- R4: Any other opcode with bit 7 clear produces no pulse and no register write, and the next byte is again taken as an opcode.
- R5: An opcode with bit 7 set takes exactly the next four accepted bytes as argument bytes. The byte after them is taken as an opcode.
- R6: The first argument byte lands in bits 7:0 of the word, the second in bits 15:8, the third in bits 23:16 and the fourth in bits 31:24.
- R7: The long opcodes map to registers as follows: 0xC0 to trigMask, 0xC1 to trigValue, 0xC2 to trigConfig, 0x80 to sampleDiv, 0x81 to countWord, 0x82 to flagWord.
- R8: A target register keeps its old value while argument bytes 1 to 3 arrive. It takes the new word in the cycle after the fourth argument byte is accepted.
- R9: In the cycle a register is written, regWe shows a single one-cycle bit. The bit positions are 0 trigMask, 1 trigValue, 2 trigConfig, 3 sampleDiv, 4 countWord, 5 flagWord.
- R10: A long opcode with bit 7 set that is not in the R7 map still consumes four argument bytes, but changes no register and raises no regWe bit.
- R11: Zero bytes taken as argument bytes raise no pulse. Five consecutive zero bytes sent in the middle of a long command finish that command and then give at least one reset pulse, after which the decoder is aligned on opcodes.
- R12: Cycles with rxValid low change nothing, whatever value rxByte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | rxByte is accepted on this clock edge |
| trigMask | output | 32 | Trigger mask register |
| trigValue | output | 32 | Trigger value register |
| trigConfig | output | 32 | Trigger configuration register |
| sampleDiv | output | 32 | Sample-rate divider register |
| countWord | output | 32 | Read/delay count register |
| flagWord | output | 32 | Flags register |
| regWe | output | 6 | One-cycle write-enable, one bit per register |
| resetPulse | output | 1 | One-cycle reset request |
| armPulse | output | 1 | One-cycle arm/run request |

## Verification
Every result is due exactly one clock after the edge that accepts the byte causing it: the pulses, the regWe bit and the new register value. The bench drives each byte on a falling edge and holds rxValid high for a single rising edge. It then samples on the following falling edge, which is the single cycle in which a pulse or write strobe is visible. It then samples again one cycle later to confirm that the strobe has dropped. Register values are also sampled after argument bytes 1 to 3, to show that nothing moves before the fourth byte.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 6;
  localparam int ARG_BYTES = DATA_W / BYTE_W;
  localparam int CNT_W     = $clog2(ARG_BYTES + 1);
  localparam int TGT_W     = $clog2(NUM_REGS);

  localparam logic [BYTE_W-1:0] OP_RESET = 8'h00;
  localparam logic [BYTE_W-1:0] OP_ARM   = 8'h01;

  typedef struct packed {
    logic             shiftEn;
    logic             commit;
    logic             tgtOk;
    logic [TGT_W-1:0] tgt;
  } ctlStrobe_t;

  function automatic logic [TGT_W:0] mapOpcode(input logic [BYTE_W-1:0] op);
    logic [TGT_W:0] res;
    case (op)
      8'hC0:   res = {1'b1, TGT_W'(0)};
      8'hC1:   res = {1'b1, TGT_W'(1)};
      8'hC2:   res = {1'b1, TGT_W'(2)};
      8'h80:   res = {1'b1, TGT_W'(3)};
      8'h81:   res = {1'b1, TGT_W'(4)};
      8'h82:   res = {1'b1, TGT_W'(5)};
      default: res = '0;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/la_cmd_ctrl.sv
module la_cmd_ctrl
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output ctlStrobe_t        strobe,
  output logic              resetPulse,
  output logic              armPulse
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ARG_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic [TGT_W-1:0] tgtIdx;
  logic             tgtOk;
  logic             atOpcode;

  assign atOpcode = (byteCnt == '0);

  always_comb begin
    strobe.shiftEn = rxValid && !atOpcode;
    strobe.commit  = rxValid && (byteCnt == LAST_CNT);
    strobe.tgtOk   = tgtOk;
    strobe.tgt     = tgtIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt    <= '0;
      tgtIdx     <= '0;
      tgtOk      <= 1'b0;
      resetPulse <= 1'b0;
      armPulse   <= 1'b0;
    end else begin
      resetPulse <= 1'b0;
      armPulse   <= 1'b0;
      if (rxValid) begin
        if (atOpcode) begin
          if (rxByte[BYTE_W-1]) begin
            byteCnt         <= CNT_W'(1);
            {tgtOk, tgtIdx} <= mapOpcode(rxByte);
          end else begin
            resetPulse <= (rxByte == OP_RESET);
            armPulse   <= (rxByte == OP_ARM);
          end
        end else if (byteCnt == LAST_CNT) begin
          byteCnt <= '0;
        end else begin
          byteCnt <= byteCnt + CNT_W'(1);
        end
      end
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_CNT);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(byteCnt) && !resetPulse && !armPulse);

  p_arg_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && byteCnt != '0) |=> !resetPulse && !armPulse);

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(resetPulse && armPulse));

  p_reset_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> $past(rxValid && rxByte == OP_RESET && byteCnt == '0));
endmodule

// File: rtl/la_cmd_dpath.sv
module la_cmd_dpath
  import la_cmd_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [BYTE_W-1:0]                rxByte,
  input  ctlStrobe_t                       strobe,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regFile,
  output logic [NUM_REGS-1:0]              regWe
);
  logic [DATA_W-1:0] argSh;
  logic [DATA_W-1:0] argNext;

  assign argNext = {rxByte, argSh[DATA_W-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (!rstN)               argSh <= '0;
    else if (strobe.shiftEn) argSh <= argNext;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = strobe.commit && strobe.tgtOk && (strobe.tgt == TGT_W'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regFile[k] <= '0;
        regWe[k]   <= 1'b0;
      end else begin
        regWe[k] <= hit;
        if (hit) regFile[k] <= argNext;
      end
    end

    p_hold_unless_we_r8: assert property (@(posedge clk) disable iff (!rstN)
      !regWe[k] |-> $stable(regFile[k]));
  end

  p_we_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWe));

  p_we_needs_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe != '0) |-> $past(strobe.commit && strobe.tgtOk));
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  output logic [31:0]       trigMask,
  output logic [31:0]       trigValue,
  output logic [31:0]       trigConfig,
  output logic [31:0]       sampleDiv,
  output logic [31:0]       countWord,
  output logic [31:0]       flagWord,
  output logic [5:0]        regWe,
  output logic              resetPulse,
  output logic              armPulse
);
  ctlStrobe_t                      strobe;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;

  la_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxByte     (rxByte),
    .rxValid    (rxValid),
    .strobe     (strobe),
    .resetPulse (resetPulse),
    .armPulse   (armPulse)
  );

  la_cmd_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .rxByte  (rxByte),
    .strobe  (strobe),
    .regFile (regFile),
    .regWe   (regWe)
  );

  assign trigMask   = regFile[0];
  assign trigValue  = regFile[1];
  assign trigConfig = regFile[2];
  assign sampleDiv  = regFile[3];
  assign countWord  = regFile[4];
  assign flagWord   = regFile[5];
endmodule

// File: tb/la_cmd_decoder_tb.sv
module la_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0;
  logic [31:0] trigMask, trigValue, trigConfig, sampleDiv, countWord, flagWord;
  logic [5:0]  regWe;
  logic        resetPulse, armPulse;

  int          nChecks = 0;
  int          nFails = 0;
  logic [31:0] expReg [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .trigMask(trigMask), .trigValue(trigValue), .trigConfig(trigConfig),
    .sampleDiv(sampleDiv), .countWord(countWord), .flagWord(flagWord),
    .regWe(regWe), .resetPulse(resetPulse), .armPulse(armPulse)
  );

  function automatic logic [31:0] getReg(input int i);
    case (i)
      0: return trigMask;
      1: return trigValue;
      2: return trigConfig;
      3: return sampleDiv;
      4: return countWord;
      default: return flagWord;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAllRegs(input string req);
    for (int i = 0; i < 6; i++) check(req, getReg(i), expReg[i]);
  endtask

  // Drive one byte for one rising edge; return at the falling edge after it.
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxByte  = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    rxByte  = 8'hxx ^ 8'h00;
    rxByte  = 8'h5A;
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < 6; i++) expReg[i] = '0;
    checkAllRegs("R1 regs");
    check("R1 regWe", {26'b0, regWe}, '0);
    check("R1 pulses", {30'b0, resetPulse, armPulse}, '0);
  endtask

  task automatic t_long(input logic [7:0] op, input int idx, input logic [31:0] arg);
    sendByte(op);
    check("R5 no we after opcode", {26'b0, regWe}, '0);
    for (int j = 0; j < 4; j++) begin
      sendByte(arg[8*j +: 8]);
      if (j < 3) begin
        check("R8 hold before last byte", {26'b0, regWe}, '0);
        checkAllRegs("R8 regs unchanged");
        check("R11 no pulse on arg byte", {30'b0, resetPulse, armPulse}, '0);
      end
    end
    if (idx >= 0) begin
      expReg[idx] = arg;
      check("R9 regWe bit", {26'b0, regWe}, 32'(1) << idx);
    end else begin
      check("R10 no we for unknown", {26'b0, regWe}, '0);
    end
    checkAllRegs("R6 R7 register contents");
    @(negedge clk);
    check("R9 regWe one cycle", {26'b0, regWe}, '0);
  endtask

  task automatic t_map;
    t_long(8'hC0, 0, 32'h1234_5678);
    t_long(8'hC1, 1, 32'hA1B2_C3D4);
    t_long(8'hC2, 2, 32'h0F0F_00FF);
    t_long(8'h80, 3, 32'h0000_0063);
    t_long(8'h81, 4, 32'hFF01_FF01);
    t_long(8'h82, 5, 32'h0000_0002);
    t_long(8'hC0, 0, 32'h8000_0001);
  endtask

  task automatic t_short;
    sendByte(8'h00);
    check("R2 resetPulse", {31'b0, resetPulse}, 32'd1);
    check("R2 no arm", {31'b0, armPulse}, '0);
    @(negedge clk);
    check("R2 pulse width", {31'b0, resetPulse}, '0);
    checkAllRegs("R2 regs kept");
    sendByte(8'h01);
    check("R3 armPulse", {31'b0, armPulse}, 32'd1);
    check("R3 no reset", {31'b0, resetPulse}, '0);
    @(negedge clk);
    check("R3 pulse width", {31'b0, armPulse}, '0);
  endtask

  task automatic t_unknown_short;
    sendByte(8'h05);
    check("R4 no pulse", {30'b0, resetPulse, armPulse}, '0);
    check("R4 no we", {26'b0, regWe}, '0);
    sendByte(8'h7F);
    check("R4 no pulse 7F", {30'b0, resetPulse, armPulse}, '0);
    t_long(8'hC1, 1, 32'h0BAD_F00D);
  endtask

  task automatic t_unknown_long;
    t_long(8'hA5, -1, 32'h0100_0001);
    sendByte(8'h01);
    check("R5 R10 next byte is opcode", {31'b0, armPulse}, 32'd1);
    checkAllRegs("R10 regs unchanged");
  endtask

  task automatic t_zero_flush;
    int nRst = 0;
    sendByte(8'h81);
    sendByte(8'h34);
    sendByte(8'h12);
    for (int j = 0; j < 5; j++) begin
      sendByte(8'h00);
      if (resetPulse) nRst++;
    end
    expReg[4] = 32'h0000_1234;
    checkAllRegs("R11 partial command finished by zeros");
    check("R11 reset pulses seen", 32'(nRst), 32'd3);
    sendByte(8'h01);
    check("R11 aligned after flush", {31'b0, armPulse}, 32'd1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    rxByte = 8'h01;
    repeat (4) begin
      @(negedge clk);
      check("R12 no arm while invalid", {31'b0, armPulse}, '0);
    end
    rxByte = 8'hC0;
    repeat (3) @(negedge clk);
    sendByte(8'h00);
    check("R12 still at opcode", {31'b0, resetPulse}, 32'd1);
    checkAllRegs("R12 regs unchanged");
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_map();
    t_short();
    t_unknown_short();
    t_unknown_long();
    t_zero_flush();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule